// File: doc/BRIEF.md
# Nibble-Framed Three-Wire Serial Master

This block is the host-side engine for a three-wire serial link to a small clock-calendar device whose registers are four bits wide. It drives a chip-enable line and a serial clock, and it drives or releases a shared bidirectional data line through an output-enable. A user-side request/acknowledge handshake supplies a read-or-write flag, a 4-bit register address and 4-bit write data. For a read, the handshake returns 4-bit data.

Every access is a 16-bit frame. The frame opens with a 4-bit control nibble that encodes the direction and a phase flag, then carries the address. A write then sends a second control nibble and the four data bits. A read releases the data line, discards four turnaround bits and captures four data bits. The half-bit time and the chip-enable settle time are parameters counted in system clock cycles.

Chip enable follows a separate command input, so a higher-level sequencer can keep it asserted across several accesses. A change of that input is applied only between frames, and each change is followed by a settle period before the next frame may start.

Top module: `nibble_serial_master`

## Requirements
- R1: While reset is held and right after it, ce_o is 0, sclk_o is 1, sio_o is 1, sio_oe is 1, busy is 0 and ack is 0.
- R2: A read frame sends eight bits, most significant first: control nibble 1,1,1,0 and then address bits A3 down to A0.
- R3: A write frame sends sixteen bits: 1,0,1,0, then A3..A0, then 1,0,0,1, then D3..D0.
- R4: During a read, sio_oe is 0 for frame bits 8 to 15 and 1 for bits 0 to 7. In a write, sio_oe stays 1 for the whole frame. sio_oe is 1 again once the frame ends.
- R5: In a read, the four sio_i bits clocked at frame bits 8 to 11 have no effect. rdata holds the bits clocked at frame bits 12 to 15, with the first of them as bit 3. Each bit is sampled at the end of its high half, on the system clock edge that drives sclk_o low.
- R6: Each bit holds sclk_o high for HALF_CYC cycles with sio_o already set up, and then holds sclk_o low for HALF_CYC cycles. Successive falling edges of sclk_o are 2*HALF_CYC cycles apart, and sio_o does not change on a falling edge.
- R7: busy rises on the cycle a request is accepted and stays high until ack. ack is a one-cycle pulse that occurs while busy is high.
- R8: ce_o follows ce_cmd only while no frame is in progress. A change of ce_cmd during a frame takes effect within two cycles after ack.
- R9: After ce_o changes, a pending request is accepted exactly SETTLE_CYC+1 cycles later, measured as the number of cycles in which ce_o shows its new value while busy is still 0.
- R10: Between frames, sclk_o is 1, sio_o is 1 and sio_oe is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_cmd | input | 1 | Requested chip-enable level |
| req | input | 1 | Access request, held until ack |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access in progress |
| rdata | output | 4 | Data returned by the last read |
| ce_o | output | 1 | Chip enable to the device |
| sclk_o | output | 1 | Serial clock |
| sio_o | output | 1 | Serial data out |
| sio_oe | output | 1 | Output enable of the data line |
| sio_i | input | 1 | Serial data in |

## Verification
On every cycle, the assertions check the following. The data line is released and the serial clock is low only inside a busy access. ack occurs while busy is high and lasts a single cycle. The data output holds steady across each falling clock edge. Chip enable never moves while busy is high.

Only the bench scenarios can show the bit order of read and write frames, which turnaround bits are discarded, and the exact half-bit and settle cycle counts. The same holds for the deferral of a chip-enable change that arrives in the middle of a frame.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
  localparam int NIB        = 4;
  localparam int FRAME_BITS = 4 * NIB;

  localparam logic [NIB-1:0] CTL_READ  = 4'b1110;
  localparam logic [NIB-1:0] CTL_WADDR = 4'b1010;
  localparam logic [NIB-1:0] CTL_WDATA = 4'b1001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_HI,
    ST_LO,
    ST_ACK
  } nsm_state_e;
endpackage

// File: rtl/nsm_phase_timer.sv
module nsm_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [TW-1:0] limit,
  output logic          hit
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == limit - 1'b1);
endmodule

// File: rtl/nsm_frame_fmt.sv
module nsm_frame_fmt
  import nsm_pkg::*;
(
  input  logic                  rd,
  input  logic [NIB-1:0]        addr,
  input  logic [NIB-1:0]        wdata,
  output logic [FRAME_BITS-1:0] frame
);
  always_comb begin
    if (rd) frame = {CTL_READ, addr, {(2*NIB){1'b1}}};
    else    frame = {CTL_WADDR, addr, CTL_WDATA, wdata};
  end
endmodule

// File: rtl/nsm_rx_shift.sv
module nsm_rx_shift #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/nibble_serial_master.sv
module nibble_serial_master
  import nsm_pkg::*;
#(
  parameter int HALF_CYC   = 4,
  parameter int SETTLE_CYC = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce_cmd,
  input  logic           req,
  input  logic           rd_nwr,
  input  logic [NIB-1:0] addr,
  input  logic [NIB-1:0] wdata,
  output logic           ack,
  output logic           busy,
  output logic [NIB-1:0] rdata,
  output logic           ce_o,
  output logic           sclk_o,
  output logic           sio_o,
  output logic           sio_oe,
  input  logic           sio_i
);
  localparam int MAXC   = (HALF_CYC > SETTLE_CYC) ? HALF_CYC : SETTLE_CYC;
  localparam int TW     = $clog2(MAXC + 1) + 1;
  localparam int BW     = $clog2(FRAME_BITS);
  localparam int LAST   = FRAME_BITS - 1;
  localparam int REL_AT = 2 * NIB - 1;
  localparam int CAP_AT = 3 * NIB;

  nsm_state_e            state;
  logic [BW-1:0]         bit_idx;
  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] frame;
  logic                  rd_q;
  logic                  hit;
  logic                  tmr_clr;
  logic [TW-1:0]         limit;
  logic                  cap_en;
  logic [NIB-1:0]        rx_q;

  nsm_frame_fmt u_fmt (
    .rd    (rd_nwr),
    .addr  (addr),
    .wdata (wdata),
    .frame (frame)
  );

  assign limit   = (state == ST_SETTLE) ? TW'(SETTLE_CYC) : TW'(HALF_CYC);
  assign tmr_clr = (state == ST_IDLE) || (state == ST_ACK) || hit;

  nsm_phase_timer #(.TW(TW)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .limit (limit),
    .hit   (hit)
  );

  assign cap_en = (state == ST_HI) && hit && rd_q && (bit_idx >= BW'(CAP_AT));

  nsm_rx_shift #(.W(NIB)) u_rx (
    .clk (clk),
    .rst (rst),
    .en  (cap_en),
    .din (sio_i),
    .q   (rx_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ce_o    <= 1'b0;
      sclk_o  <= 1'b1;
      sio_o   <= 1'b1;
      sio_oe  <= 1'b1;
      ack     <= 1'b0;
      busy    <= 1'b0;
      bit_idx <= '0;
      shreg   <= '0;
      rd_q    <= 1'b0;
      rdata   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ce_cmd != ce_o) begin
            ce_o  <= ce_cmd;
            state <= ST_SETTLE;
          end else if (req) begin
            busy    <= 1'b1;
            rd_q    <= rd_nwr;
            shreg   <= frame;
            sio_o   <= frame[LAST];
            bit_idx <= '0;
            state   <= ST_HI;
          end
        end
        ST_SETTLE: begin
          if (hit) state <= ST_IDLE;
        end
        ST_HI: begin
          if (hit) begin
            sclk_o <= 1'b0;
            state  <= ST_LO;
          end
        end
        ST_LO: begin
          if (hit) begin
            sclk_o <= 1'b1;
            if (bit_idx == BW'(LAST)) begin
              sio_o  <= 1'b1;
              sio_oe <= 1'b1;
              ack    <= 1'b1;
              if (rd_q) rdata <= rx_q;
              state  <= ST_ACK;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              sio_o   <= shreg[LAST-1];
              shreg   <= {shreg[LAST-1:0], 1'b0};
              if (rd_q && bit_idx == BW'(REL_AT)) sio_oe <= 1'b0;
              state   <= ST_HI;
            end
          end
        end
        ST_ACK: begin
          ack   <= 1'b0;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  oe_inside_access_chk: assert property (@(posedge clk) disable iff (rst)
    !sio_oe |-> busy);

  // R10
  sclk_low_inside_access_chk: assert property (@(posedge clk) disable iff (rst)
    !sclk_o |-> busy);

  // R7
  ack_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> busy);

  // R7
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R6
  data_steady_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> $stable(sio_o));

  // R8
  ce_frozen_in_access_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ce_o));
endmodule

// File: tb/sim_nibble_serial_master.sv
module sim_nibble_serial_master;
  localparam int H = 4;
  localparam int S = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_cmd = 1'b0, req = 1'b0, rd_nwr = 1'b0;
  logic [3:0] addr = '0, wdata = '0;
  logic ack, busy, ce_o, sclk_o, sio_o, sio_oe, sio_i;
  logic [3:0] rdata;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [3:0] dev_data = '0, dev_garb = '0;
  int nb = 0;
  logic [15:0] bv = '0, ov = '0;
  int since_fall = 0, low_run = 0;
  bit tbad = 0;
  logic prev_sclk = 1'b1;

  always #10 clk = ~clk;

  nibble_serial_master #(.HALF_CYC(H), .SETTLE_CYC(S)) u0 (
    .clk(clk), .rst(rst), .ce_cmd(ce_cmd), .req(req), .rd_nwr(rd_nwr),
    .addr(addr), .wdata(wdata), .ack(ack), .busy(busy), .rdata(rdata),
    .ce_o(ce_o), .sclk_o(sclk_o), .sio_o(sio_o), .sio_oe(sio_oe), .sio_i(sio_i)
  );

  // device model: drives the line while the master has released it
  assign sio_i = sio_oe ? sio_o :
                 (nb >= 8 && nb < 12)  ? dev_garb[11-nb] :
                 (nb >= 12 && nb < 16) ? dev_data[15-nb] : 1'b1;

  always @(negedge clk) begin
    since_fall++;
    if (prev_sclk && !sclk_o) begin
      if (nb < 16) begin
        bv[15-nb] = sio_o;
        ov[15-nb] = sio_oe;
      end
      if (nb > 0 && since_fall != 2*H) tbad = 1;
      since_fall = 0;
      nb++;
    end
    if (!sclk_o) low_run++;
    if (!prev_sclk && sclk_o) begin
      if (low_run != H) tbad = 1;
      low_run = 0;
    end
    prev_sclk = sclk_o;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    nb = 0; bv = '0; ov = '0; tbad = 0; since_fall = 0; low_run = 0;
  endtask

  task automatic wait_ack_busy(output bit busy_ok);
    busy_ok = 1;
    while (!busy) @(negedge clk);
    while (!ack) begin
      @(negedge clk);
      if (!busy) busy_ok = 0;
    end
    req = 1'b0;
  endtask

  task automatic do_access(input bit rd, input logic [3:0] a, input logic [3:0] d,
                           input logic [3:0] dd, input logic [3:0] dg);
    bit bok;
    logic [15:0] exp_bits;
    @(negedge clk);
    mon_clear();
    dev_data = dd; dev_garb = dg;
    rd_nwr = rd; addr = a; wdata = d; req = 1'b1;
    wait_ack_busy(bok);
    check(bok, "R7 busy held to ack", int'(bok), 1);
    @(negedge clk);
    check(!ack, "R7 ack one cycle", int'(ack), 0);
    check(nb == 16, "R6 sixteen clocks", nb, 16);
    check(!tbad, "R6 half-bit timing", int'(tbad), 0);
    if (rd) begin
      exp_bits = {4'b1110, a, 8'h00};
      check(bv[15:8] == exp_bits[15:8], "R2 read header", int'(bv[15:8]), int'(exp_bits[15:8]));
      check(ov == 16'hFF00, "R4 read release", int'(ov), 16'hFF00);
      check(rdata == dd, "R5 read data", int'(rdata), int'(dd));
    end else begin
      exp_bits = {4'b1010, a, 4'b1001, d};
      check(bv == exp_bits, "R3 write frame", int'(bv), int'(exp_bits));
      check(ov == 16'hFFFF, "R4 write drives", int'(ov), 16'hFFFF);
    end
    check(sclk_o && sio_o && sio_oe && !busy, "R10 idle lines",
          int'({sclk_o, sio_o, sio_oe, busy}), 4'b1110);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check({ce_o, sclk_o, sio_o, sio_oe, busy, ack} == 6'b011100, "R1 in reset",
          int'({ce_o, sclk_o, sio_o, sio_oe, busy, ack}), 6'b011100);
    rst = 1'b0;
    @(negedge clk);
    check({ce_o, sclk_o, sio_o, sio_oe, busy, ack} == 6'b011100, "R1 after reset",
          int'({ce_o, sclk_o, sio_o, sio_oe, busy, ack}), 6'b011100);
  endtask

  task automatic t_settle();
    int cnt = 0;
    bit bok;
    @(negedge clk);
    mon_clear();
    rd_nwr = 1'b0; addr = 4'h2; wdata = 4'h9;
    ce_cmd = 1'b1; req = 1'b1;
    while (!busy) begin
      @(negedge clk);
      if (ce_o && !busy) cnt++;
    end
    check(cnt == S + 1, "R9 settle cycles", cnt, S + 1);
    wait_ack_busy(bok);
    @(negedge clk);
  endtask

  task automatic t_ce_defer();
    bit bok;
    @(negedge clk);
    mon_clear();
    rd_nwr = 1'b1; addr = 4'h7; dev_data = 4'h6; dev_garb = 4'h9; req = 1'b1;
    repeat (20) @(negedge clk);
    ce_cmd = 1'b0;
    wait_ack_busy(bok);
    check(ce_o == 1'b1, "R8 ce held in frame", int'(ce_o), 1);
    repeat (2) @(negedge clk);
    check(ce_o == 1'b0, "R8 ce applied after", int'(ce_o), 0);
    check(rdata == 4'h6, "R5 read under ce change", int'(rdata), 4'h6);
    repeat (S + 2) @(negedge clk);
  endtask

  initial begin
    t_reset();
    do_access(1'b0, 4'hD, 4'h6, 4'h0, 4'h0);
    do_access(1'b1, 4'h5, 4'h0, 4'hA, 4'h5);
    do_access(1'b1, 4'hC, 4'h0, 4'h3, 4'hC);
    do_access(1'b0, 4'h0, 4'hF, 4'h0, 4'h0);
    do_access(1'b0, 4'hF, 4'h0, 4'h0, 4'h0);
    t_settle();
    do_access(1'b1, 4'h8, 4'h0, 4'hF, 4'h0);
    t_ce_defer();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule